// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is an 8-bit SPI port that can run as the bus master or as a slave, sharing one shift register between the two roles. The register side sets an enable bit, a master request bit, a two-bit select-mode field and a divider for the generated serial clock. It loads outgoing bytes with a write strobe and collects received bytes through a read strobe that also acknowledges a completion flag. The pin side presents MOSI, MISO, SCK and NSS as separate input, output and output-enable signals, so the pad ring can build the tristate drivers.

The clock mode is fixed: SCK idles low, data is sampled on the rising edge and the next bit is shifted out on the falling edge, most significant bit first. As master, the port generates SCK with a period of 2×(divider+1) system clocks and samples MISO directly. As slave, SCK, MOSI and NSS pass through a two-flop synchronizer, and the port detects edges on the synchronized copies, so the external bit clock must be well below the system clock.

The select-mode field decides what NSS means. In mode 00 it is unused and a slave is always selected. In mode 01 it is a select input for a slave, and for a master it is a contention input: a falling NSS takes the port out of the master role and raises a fault. In modes 10 and 11 NSS is driven with the low bit of the field, for a master that selects one slave under software control.

Top module: `spi_dual_port`

## Requirements
- R1: Out of reset all four output enables are low, `sck_o` is low, and `done` and `mode_fault` are low.
- R2: As master, a `tx_wr` while idle starts a byte. `mosi_o` shows the written byte most significant bit first and is stable at each rising `sck_o`. `sck_o` idles low and has a period of 2×(`cfg_div`+1) clocks. `miso_i` is sampled at each rising `sck_o`, and the eight sampled bits, first bit in bit 7, appear on `rx_data`.
- R3: `done` sets after the eighth bit of a byte in either role and stays set until `rx_rd`. If the flag sets in the same cycle as `rx_rd`, setting wins.
- R4: An enabled port in the master role drives `mosi_oe` and `sck_oe` high and keeps `miso_oe` low.
- R5: In select-mode 00 an enabled slave drives `miso_oe` high at all times. It receives on MOSI and sends the byte loaded by `tx_wr` on `miso_o`, most significant bit first.
- R6: In select-mode 01 a slave with `nss_i` high keeps `miso_oe` low and ignores SCK edges: no bit is counted and `done` does not set. With `nss_i` low it transfers normally.
- R7: With `cfg_en` low all four output enables are low.
- R8: In select-modes 10 and 11 with the port enabled, `nss_oe` is high and `nss_o` equals bit 0 of `cfg_selmode`.
- R9: In select-mode 01, a falling `nss_i` while the port is master sets `mode_fault`, aborts the byte (`sck_o` low, no `done`) and drops `mosi_oe` and `sck_oe`. The fault clears when `cfg_master` is low.
- R10: In select-modes 00 and 1x a falling `nss_i` never sets `mode_fault`, and master transfers continue to work.
- R11: A 4-wire slave that is deselected part-way through a byte discards the bits already counted. After it is selected again, eight new SCK cycles are needed before `done` sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | Request the master role |
| cfg_selmode | input | 2 | Select mode: 00 3-wire, 01 4-wire slave/multi-master, 1x 4-wire master with NSS driven |
| cfg_div | input | DIV_W | Master SCK half-period in clocks, minus one |
| tx_wr | input | 1 | Load `tx_data` into the shift register |
| tx_data | input | 8 | Byte to send |
| rx_rd | input | 1 | Acknowledge the received byte and clear `done` |
| rx_data | output | 8 | Last completed received byte |
| done | output | 1 | Byte-complete flag |
| mode_fault | output | 1 | Multi-master contention flag |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO output enable |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output |
| sck_oe | output | 1 | SCK output enable |
| nss_i | input | 1 | NSS pin input |
| nss_o | output | 1 | NSS pin output |
| nss_oe | output | 1 | NSS output enable |

## Verification
The byte-complete event that sets `done` can land in the same cycle as a software `rx_rd`. If the clear won, a finished byte would go unseen. The bench provokes this by holding `rx_rd` high for a whole master transfer. It then expects `done` to be high for exactly one sampled cycle, and the scoreboard still receives the byte in that window. A fault is also provoked while a transfer is running, to confirm that the abort leaves no stray completion behind.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_3WIRE     = 2'b00,
    SEL_4W_MULTI  = 2'b01,
    SEL_4W_DRV_LO = 2'b10,
    SEL_4W_DRV_HI = 2'b11
  } sel_mode_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= RST_VAL;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == div);

  // R2: the half-period counter never runs past the divider while it runs
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (run && $stable(div)) |-> (cnt_q <= div));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clear,
  input  logic         rise_ev,
  input  logic         fall_ev,
  input  logic         din,
  output logic         msb,
  output logic         byte_done,
  output logic         at_last,
  output logic         cnt_zero,
  output logic [W-1:0] rx_byte
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W-1);

  logic [W-1:0]     sreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sample_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q    <= '0;
      cnt_q     <= '0;
      sample_q  <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
      end else begin
        if (rise_ev) sample_q <= din;
        if (fall_ev) begin
          sreg_q <= {sreg_q[W-2:0], sample_q};
          if (cnt_q == LAST) begin
            cnt_q     <= '0;
            byte_done <= 1'b1;
            rx_byte   <= {sreg_q[W-2:0], sample_q};
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
      if (load) sreg_q <= load_val;
    end
  end

  assign msb      = sreg_q[W-1];
  assign at_last  = (cnt_q == LAST);
  assign cnt_zero = (cnt_q == '0);

  // R3: completion is a single-cycle event
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);
  // R11: a cleared counter restarts from zero
  assert_clear_restart_R11: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt_zero);
endmodule

// File: rtl/spi_dual_port.sv
module spi_dual_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_master,
  input  logic [1:0]       cfg_selmode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic             mode_fault,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             nss_i,
  output logic             nss_o,
  output logic             nss_oe
);
  localparam int unsigned W = BYTE_W;

  sel_mode_e mode;
  assign mode = sel_mode_e'(cfg_selmode);

  // synchronized slave-side pins: {nss, mosi, sck}
  logic [2:0] pin_s;
  logic       nss_s, mosi_s, sck_s;

  spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({nss_i, mosi_i, sck_i}),
    .q   (pin_s)
  );
  assign nss_s  = pin_s[2];
  assign mosi_s = pin_s[1];
  assign sck_s  = pin_s[0];

  logic sck_prev_q, nss_prev_q;
  logic fault_q, m_busy_q, sck_q;
  logic role_m, slave_sel, slave_act;
  logic s_rise, s_fall, nss_fall, fault_hit;
  logic m_start, s_load, m_tick, m_rise, m_fall;
  logic core_rise, core_fall, core_din, core_clear, core_load;
  logic core_msb, core_done, core_last, core_zero;
  logic [W-1:0] core_rx;

  assign role_m = cfg_master && !fault_q;

  always_comb begin
    unique case (mode)
      SEL_3WIRE:    slave_sel = 1'b1;
      SEL_4W_MULTI: slave_sel = !nss_s;
      default:      slave_sel = 1'b0;
    endcase
  end

  assign slave_act = cfg_en && !role_m && slave_sel;
  assign s_rise    = slave_act && sck_s && !sck_prev_q;
  assign s_fall    = slave_act && !sck_s && sck_prev_q;
  assign nss_fall  = nss_prev_q && !nss_s;
  assign fault_hit = cfg_en && role_m && (mode == SEL_4W_MULTI) && nss_fall;

  assign m_start = cfg_en && role_m && tx_wr && !m_busy_q;
  assign s_load  = cfg_en && !role_m && tx_wr && core_zero;

  spi_sck_gen #(.DIV_W(DIV_W)) u_sck_gen (
    .clk  (clk),
    .rst  (rst),
    .run  (m_busy_q),
    .div  (cfg_div),
    .tick (m_tick)
  );

  assign m_rise = m_tick && !sck_q;
  assign m_fall = m_tick && sck_q;

  assign core_rise  = role_m ? m_rise : s_rise;
  assign core_fall  = role_m ? m_fall : s_fall;
  assign core_din   = role_m ? miso_i : mosi_s;
  assign core_clear = !cfg_en || fault_hit || (!role_m && !slave_sel);
  assign core_load  = m_start || s_load;

  spi_shift_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (core_load),
    .load_val  (tx_data),
    .clear     (core_clear),
    .rise_ev   (core_rise),
    .fall_ev   (core_fall),
    .din       (core_din),
    .msb       (core_msb),
    .byte_done (core_done),
    .at_last   (core_last),
    .cnt_zero  (core_zero),
    .rx_byte   (core_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev_q <= 1'b0;
      nss_prev_q <= 1'b1;
      fault_q    <= 1'b0;
      m_busy_q   <= 1'b0;
      sck_q      <= 1'b0;
      done       <= 1'b0;
      mosi_oe    <= 1'b0;
      sck_oe     <= 1'b0;
      miso_oe    <= 1'b0;
      nss_oe     <= 1'b0;
      nss_o      <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      nss_prev_q <= nss_s;

      if (fault_hit)        fault_q <= 1'b1;
      else if (!cfg_master) fault_q <= 1'b0;

      if (fault_hit || !cfg_en || !role_m) begin
        m_busy_q <= 1'b0;
        sck_q    <= 1'b0;
      end else if (m_start) begin
        m_busy_q <= 1'b1;
      end else if (m_rise) begin
        sck_q <= 1'b1;
      end else if (m_fall) begin
        sck_q <= 1'b0;
        if (core_last) m_busy_q <= 1'b0;
      end

      if (core_done)  done <= 1'b1;
      else if (rx_rd) done <= 1'b0;

      mosi_oe <= cfg_en && role_m;
      sck_oe  <= cfg_en && role_m;
      miso_oe <= slave_act;
      nss_oe  <= cfg_en && cfg_selmode[1];
      nss_o   <= cfg_selmode[0];
    end
  end

  assign mode_fault = fault_q;
  assign sck_o      = sck_q;
  assign mosi_o     = core_msb;
  assign miso_o     = core_msb;
  assign rx_data    = core_rx;

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !m_busy_q |-> !sck_q);
  assert_done_set_R3: assert property (@(posedge clk) disable iff (rst)
    core_done |=> done);
  assert_master_miso_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && role_m) |=> (!miso_oe && mosi_oe && sck_oe));
  assert_deselect_float_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !role_m && mode == SEL_4W_MULTI && nss_s) |=> !miso_oe);
  assert_disabled_float_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !(mosi_oe || miso_oe || sck_oe || nss_oe));
  assert_nss_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_selmode[1]) |=> (nss_oe && nss_o == $past(cfg_selmode[0])));
  assert_fault_mode_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_fault) |-> ($past(cfg_selmode) == 2'b01));
  assert_fault_release_R9: assert property (@(posedge clk) disable iff (rst)
    mode_fault |=> !(mosi_oe || sck_oe || sck_o));
endmodule

// File: tb/sim_spi_dual_port.sv
module sim_spi_dual_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0, cfg_master = 1'b0;
  logic [1:0] cfg_selmode = 2'b00;
  logic [7:0] cfg_div = 8'd1;
  logic       tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic       done, mode_fault;
  logic       mosi_i = 1'b0, miso_i = 1'b0, sck_i = 1'b0, nss_i = 1'b1;
  logic       mosi_o, mosi_oe, miso_o, miso_oe, sck_o, sck_oe, nss_o, nss_oe;

  int n_checks = 0, n_fail = 0, cyc = 0, done_hi = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q [$];
  bit done_seen = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_dual_port u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_selmode(cfg_selmode), .cfg_div(cfg_div), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .done(done),
    .mode_fault(mode_fault), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .nss_i(nss_i),
    .nss_o(nss_o), .nss_oe(nss_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every new completion pops one expected byte
  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_hi <= done_hi + 1;
      if (done && !done_seen) begin
        done_seen = 1'b1;
        if (exp_q.size() == 0) check("R3 unexpected done", 32'(rx_data), 32'hFFFF);
        else check("R2/R3 scoreboard rx_data", 32'(rx_data), 32'(exp_q.pop_front()));
      end else if (!done) begin
        done_seen = 1'b0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic load_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
  endtask

  // bench as slave device: returns what the master put on MOSI
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] mi, input int div);
    logic [7:0] got = 8'h00;
    int t1 = 0, t2 = 0;
    cfg_div = 8'(div);
    exp_q.push_back(mi);
    @(negedge clk); miso_i = mi[7];
    load_tx(tx);
    for (int b = 0; b < 8; b++) begin
      while (sck_o !== 1'b1) @(negedge clk);
      got[7-b] = mosi_o;
      if (b == 0) t1 = cyc;
      if (b == 1) t2 = cyc;
      while (sck_o !== 1'b0) @(negedge clk);
      if (b < 7) miso_i = mi[6-b];
    end
    check("R2 mosi stream MSB first", 32'(got), 32'(tx));
    check("R2 sck period", 32'(t2 - t1), 32'(2 * (div + 1)));
    idle(4);
  endtask

  // bench as master device: sends bits first..first+cnt-1 of mo, returns MISO bits
  task automatic slave_bits(input logic [7:0] mo, input int first, input int cnt,
                            output logic [7:0] got);
    got = 8'h00;
    for (int i = first; i < first + cnt; i++) begin
      @(negedge clk); sck_i = 1'b0; mosi_i = mo[7-i];
      idle(8);
      got[7-i] = miso_o;
      sck_i = 1'b1;
      idle(8);
    end
    @(negedge clk); sck_i = 1'b0;
    idle(8);
  endtask

  initial begin
    logic [7:0] g;
    idle(3);
    // R1 reset state
    check("R1 oe after reset", {mosi_oe, miso_oe, sck_oe, nss_oe}, 4'b0000);
    check("R1 sck/done/fault after reset", {sck_o, done, mode_fault}, 3'b000);
    @(negedge clk); rst = 1'b0;
    idle(2);

    // R7 disabled
    cfg_master = 1'b1; cfg_selmode = 2'b11;
    idle(3);
    check("R7 all oe low when disabled", {mosi_oe, miso_oe, sck_oe, nss_oe}, 4'b0000);

    // R8 driven select
    cfg_en = 1'b1; idle(3);
    check("R8 nss driven high", {nss_oe, nss_o}, 2'b11);
    cfg_selmode = 2'b10; idle(3);
    check("R8 nss driven low", {nss_oe, nss_o}, 2'b10);
    check("R4 master oe", {mosi_oe, sck_oe, miso_oe}, 3'b110);

    // R2 master transfers at several dividers
    master_xfer(8'hA5, 8'h3C, 1);
    check("R3 done set after byte", 32'(done), 1);
    pulse_rd(); idle(1);
    check("R3 done cleared by rx_rd", 32'(done), 0);
    master_xfer(8'h81, 8'h7E, 0); pulse_rd();
    master_xfer(8'h5A, 8'hC3, 3); pulse_rd();

    // R10 nss falls in 3-wire and driven-select modes: no fault
    cfg_selmode = 2'b00; nss_i = 1'b1; idle(4); nss_i = 1'b0; idle(6);
    check("R10 no fault in mode 00", 32'(mode_fault), 0);
    cfg_selmode = 2'b11; nss_i = 1'b1; idle(4); nss_i = 1'b0; idle(6);
    check("R10 no fault in mode 11", 32'(mode_fault), 0);
    master_xfer(8'h0F, 8'hF0, 2); pulse_rd();
    nss_i = 1'b1;

    // R3 clear and set in the same cycle: hold rx_rd through a transfer
    done_hi = 0;
    @(negedge clk); rx_rd = 1'b1;
    master_xfer(8'h96, 8'h69, 1);
    @(negedge clk); rx_rd = 1'b0;
    check("R3 set wins over rx_rd", 32'(done_hi), 1);

    // R9 contention fault mid-transfer
    cfg_selmode = 2'b01; cfg_div = 8'd3; idle(4);
    load_tx(8'hFF);
    idle(10);
    nss_i = 1'b0; idle(8);
    check("R9 fault set", 32'(mode_fault), 1);
    check("R9 master drivers released", {mosi_oe, sck_oe, sck_o}, 3'b000);
    idle(40);
    check("R9 aborted byte gives no done", 32'(done), 0);
    cfg_master = 1'b0; idle(3);
    check("R9 fault cleared by dropping master", 32'(mode_fault), 0);

    // R6 4-wire slave deselected ignores SCK
    nss_i = 1'b1; idle(6);
    check("R6 miso floats when deselected", 32'(miso_oe), 0);
    slave_bits(8'h3C, 0, 8, g);
    check("R6 no done while deselected", 32'(done), 0);
    load_tx(8'h5A);
    nss_i = 1'b0; idle(6);
    check("R6 miso driven when selected", 32'(miso_oe), 1);
    exp_q.push_back(8'hC9);
    slave_bits(8'hC9, 0, 8, g);
    check("R6 slave sends loaded byte", 32'(g), 32'h5A);
    check("R6 done after selected byte", 32'(done), 1);
    pulse_rd();

    // R11 deselect mid-byte discards partial bits
    slave_bits(8'hFF, 0, 3, g);
    nss_i = 1'b1; idle(6); nss_i = 1'b0; idle(6);
    exp_q.push_back(8'h4B);
    slave_bits(8'h4B, 0, 5, g);
    check("R11 no done after 3+5 bits", 32'(done), 0);
    slave_bits(8'h4B, 5, 3, g);
    check("R11 done after 8 fresh bits", 32'(done), 1);
    pulse_rd();

    // R5 3-wire slave always selected
    cfg_selmode = 2'b00; nss_i = 1'b1; idle(4);
    check("R5 miso driven in 3-wire slave", 32'(miso_oe), 1);
    check("R5 slave keeps mosi/sck floating", {mosi_oe, sck_oe}, 2'b00);
    load_tx(8'hE1);
    exp_q.push_back(8'h27);
    slave_bits(8'h27, 0, 8, g);
    check("R5 slave miso stream", 32'(g), 32'hE1);
    pulse_rd();

    // R7 disable again
    cfg_en = 1'b0; idle(3);
    check("R7 oe low after disable", {mosi_oe, miso_oe, sck_oe, nss_oe}, 4'b0000);
    check("R3 scoreboard drained", 32'(exp_q.size()), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule